// File: doc/BRIEF.md
# Negative-Feedback Winner-Take-All Associative Learner

This block is a two-layer binary network that learns to map input patterns onto classes using only punishment. Weights live in registers. For each presented pattern a single hidden neuron wins, the one whose weighted input sum is largest. A single output neuron then wins, chosen by the hidden-to-output weights of that hidden winner. When the output winner differs from the stored target, the weights along that one active path are weakened. When it matches, nothing changes.

A sequencer runs the stored patterns in order, one pass at a time. It counts the misclassified patterns in each pass. It stops with success after a pass that has no errors, or with failure once a pass limit is reached. A 16-bit LFSR, seeded at start, supplies the initial weights (a common mean plus a random offset) and the random remainder left after each weakening. That randomness is what allows otherwise equal neurons to separate.

Software loads patterns and targets, sets the two depression strengths and starts a run. The learned mapping can be read through a query port while the block is idle.

Top module: `lfm_learner`

## Requirements
- R1: After reset the block is idle (`busy`=0), `done`=0, `success`=0, `iteration_count`=0 and `pass_errors`=0.
- R2: While idle, a high `ld_en` writes `ld_pattern` and `ld_target` into entry `ld_idx`. A `start` pulse while idle raises `busy` and clears `done` at the next edge. With `keep_weights`=0 every weight is first reloaded from the LFSR seeded with `seed`.
- R3: The hidden winner is the neuron with the largest sum of input-to-hidden weights over the inputs that are 1, and ties go to the lowest index. The output winner is the largest hidden-to-output weight of that hidden winner, with ties again to the lowest index. While idle, `q_class` gives the output winner for `q_pattern` and is always in 0..N_OUT-1.
- R4: A pattern whose output winner equals its target changes no weight.
- R5: On a mismatch only two kinds of weight change: the weights from inputs that are 1 to the hidden winner, and the one weight from the hidden winner to the output winner. No other weight changes.
- R6: A depressed weight never rises. With a nonzero strength and a nonzero weight it strictly drops. A strength of 0 (`str_in` for the first layer, `str_out` for the second) leaves that layer's weights untouched.
- R7: At the end of every pass, `pass_errors` holds the number of that pass's patterns whose winner missed the target, the last pattern included. `iteration_count` counts completed passes.
- R8: A pass with zero errors ends the run with `done`=1, `success`=1 and `busy`=0.
- R9: When pass number MAX_PASSES still has errors, the run ends with `done`=1, `success`=0 and `iteration_count`=MAX_PASSES.
- R10: A start with `keep_weights`=1 skips weight loading and learns from the current weights. On an already-learned set it ends after exactly one pass, with success.
- R11: Six one-hot patterns (pattern p has only input p set) with six distinct targets are learned within the pass limit, after which each one-hot query returns its target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a learning run (taken only while idle) |
| keep_weights | input | 1 | 1: learn from current weights; 0: reload weights first |
| seed | input | 16 | LFSR seed captured at start (0 selects a fixed nonzero value) |
| str_in | input | 8 | First-layer depression strength, captured at start |
| str_out | input | 8 | Second-layer depression strength, captured at start |
| ld_en | input | 1 | Write one pattern entry |
| ld_idx | input | PAT_W | Pattern entry index |
| ld_pattern | input | N_IN | Binary input pattern |
| ld_target | input | OUT_W | Target class of the pattern |
| q_pattern | input | N_IN | Pattern to classify while idle |
| busy | output | 1 | Run in progress |
| done | output | 1 | Run finished (held until next start) |
| success | output | 1 | Finished run reached a clean pass |
| iteration_count | output | ITW | Completed passes of the current or last run |
| pass_errors | output | ERW | Misclassified patterns in the last completed pass |
| q_class | output | OUT_W | Output winner for `q_pattern` |

## Verification
The weakening of the last pattern's path and the error tally that closes the pass fall in the same update cycle, and the tally must include that last miss. The bench provokes this by retargeting only the final pattern of an already-learned set. It then reruns with zero strengths, so that every pass ends on that single miss, and checks that `pass_errors` equals the count predicted from a query sweep taken beforehand. A second collision pits two patterns on the same input against each other: only the first-layer row of that input may change. The bench judges this by resweeping all 64 query vectors and requiring every vector without that input bit to keep its class.

// File: rtl/lfm_pkg.sv
package lfm_pkg;

  localparam int WGT_W = 8;
  localparam int RND_W = 16;

  typedef logic [WGT_W-1:0] wgt_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_INIT,
    ST_EVAL,
    ST_UPD,
    ST_PASS
  } state_t;

  // Low byte of a left rotation of the random word; gives each weight its own draw.
  function automatic wgt_t rnd_slice(logic [RND_W-1:0] v, int n);
    logic [RND_W-1:0] r;
    r = (n == 0) ? v : ((v << n) | (v >> (RND_W - n)));
    return r[WGT_W-1:0];
  endfunction

  // Starting weight: mean minus half the spread plus a masked random offset.
  function automatic wgt_t init_wgt(wgt_t mean, int spread_bits, wgt_t r);
    int mask;
    int val;
    mask = (1 << spread_bits) - 1;
    val  = int'(mean) - (mask >> 1) + (int'(r) & mask);
    if (val < 0) val = 0;
    if (val > (1 << WGT_W) - 1) val = (1 << WGT_W) - 1;
    return wgt_t'(val);
  endfunction

  // Weakening: subtract the strength (floor 0), add a random remainder of up to
  // a quarter of the strength, and never end above the old value minus one.
  function automatic wgt_t depress_wgt(wgt_t w, wgt_t s, wgt_t r);
    logic [WGT_W:0]     base;
    logic [WGT_W:0]     cand;
    logic [WGT_W:0]     cap;
    logic [2*WGT_W-1:0] prod;
    if (s == '0) return w;
    base = (w > s) ? {1'b0, w - s} : '0;
    prod = (2*WGT_W)'(r) * (2*WGT_W)'(s);
    cand = base + (WGT_W+1)'(prod >> (WGT_W + 2));
    cap  = (w == '0) ? '0 : ({1'b0, w} - 1'b1);
    return (cand > cap) ? cap[WGT_W-1:0] : cand[WGT_W-1:0];
  endfunction

endpackage

// File: rtl/lfm_lfsr.sv
module lfm_lfsr #(
  parameter int            W    = 16,
  parameter logic [W-1:0]  TAPS = 'hB400,
  parameter logic [W-1:0]  ALT  = 'hACE1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] seed,
  output logic [W-1:0] state
);

  logic [W-1:0] nxt;

  always_comb begin
    nxt = state >> 1;
    if (state[0]) nxt = nxt ^ TAPS;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                state <= ALT;
    else if (load)             state <= (seed == '0) ? ALT : seed;
    else                       state <= nxt;
  end

  a_r2_lfsr_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (state != '0));

endmodule

// File: rtl/lfm_wta.sv
module lfm_wta #(
  parameter int N  = 18,
  parameter int SW = 11,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N*SW-1:0] score_i,
  output logic [IW-1:0]   win_o
);

  logic [SW-1:0] best;

  // Strict greater-than keeps the lowest index on a tie.
  always_comb begin
    win_o = '0;
    best  = score_i[0 +: SW];
    for (int k = 1; k < N; k++) begin
      if (score_i[k*SW +: SW] > best) begin
        best  = score_i[k*SW +: SW];
        win_o = IW'(k);
      end
    end
  end

endmodule

// File: rtl/lfm_weight_bank.sv
module lfm_weight_bank
  import lfm_pkg::*;
#(
  parameter int N_IN        = 6,
  parameter int N_HID       = 18,
  parameter int N_OUT       = 6,
  parameter int INIT_MEAN   = 192,
  parameter int SPREAD_BITS = 5,
  localparam int N_W_IN = N_IN * N_HID,
  localparam int N_W    = N_W_IN + N_HID * N_OUT,
  localparam int IDX_W  = $clog2(N_W),
  localparam int HID_W  = (N_HID > 1) ? $clog2(N_HID) : 1,
  localparam int OUT_W  = (N_OUT > 1) ? $clog2(N_OUT) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 init_en,
  input  logic [IDX_W-1:0]     init_idx,
  input  logic [RND_W-1:0]     rnd,
  input  logic                 dep_en,
  input  logic [N_IN-1:0]      dep_x,
  input  logic [HID_W-1:0]     dep_hid,
  input  logic [OUT_W-1:0]     dep_out,
  input  wgt_t                 str_in,
  input  wgt_t                 str_out,
  output logic [N_W*WGT_W-1:0] wts_o
);

  wgt_t wts [N_W];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int g = 0; g < N_W; g++) wts[g] <= '0;
    end else if (init_en) begin
      wts[init_idx] <= init_wgt(wgt_t'(INIT_MEAN), SPREAD_BITS, rnd[WGT_W-1:0]);
    end else if (dep_en) begin
      for (int i = 0; i < N_IN; i++) begin
        if (dep_x[i])
          wts[i*N_HID + int'(dep_hid)] <=
            depress_wgt(wts[i*N_HID + int'(dep_hid)], str_in, rnd_slice(rnd, (i*5) % RND_W));
      end
      wts[N_W_IN + int'(dep_hid)*N_OUT + int'(dep_out)] <=
        depress_wgt(wts[N_W_IN + int'(dep_hid)*N_OUT + int'(dep_out)], str_out,
                    rnd_slice(rnd, 13));
    end
  end

  always_comb begin
    for (int g = 0; g < N_W; g++) wts_o[g*WGT_W +: WGT_W] = wts[g];
  end

  a_r2_init_dep_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(init_en && dep_en));

  for (genvar g = 0; g < N_W; g++) begin : g_chk
    a_r6_never_rises: assert property (@(posedge clk) disable iff (!rst_n)
      dep_en |=> (wts[g] <= $past(wts[g])));
    if (g < N_W_IN) begin : g_in
      a_r5_off_path_in: assert property (@(posedge clk) disable iff (!rst_n)
        (dep_en && !(dep_x[g / N_HID] && (int'(dep_hid) == g % N_HID))) |=> $stable(wts[g]));
      a_r6_zero_str_in: assert property (@(posedge clk) disable iff (!rst_n)
        (dep_en && str_in == '0) |=> $stable(wts[g]));
    end else begin : g_out
      a_r5_off_path_out: assert property (@(posedge clk) disable iff (!rst_n)
        (dep_en && !((int'(dep_hid) == (g - N_W_IN) / N_OUT) &&
                     (int'(dep_out) == (g - N_W_IN) % N_OUT))) |=> $stable(wts[g]));
      a_r6_zero_str_out: assert property (@(posedge clk) disable iff (!rst_n)
        (dep_en && str_out == '0) |=> $stable(wts[g]));
    end
  end

endmodule

// File: rtl/lfm_learner.sv
module lfm_learner
  import lfm_pkg::*;
#(
  parameter int N_IN        = 6,
  parameter int N_HID       = 18,
  parameter int N_OUT       = 6,
  parameter int N_PAT       = 6,
  parameter int MAX_PASSES  = 10000,
  parameter int INIT_MEAN   = 192,
  parameter int SPREAD_BITS = 5,
  localparam int HID_W  = (N_HID > 1) ? $clog2(N_HID) : 1,
  localparam int OUT_W  = (N_OUT > 1) ? $clog2(N_OUT) : 1,
  localparam int PAT_W  = (N_PAT > 1) ? $clog2(N_PAT) : 1,
  localparam int ITW    = $clog2(MAX_PASSES + 1),
  localparam int ERW    = $clog2(N_PAT + 1),
  localparam int SUM_W  = WGT_W + $clog2(N_IN + 1),
  localparam int N_W_IN = N_IN * N_HID,
  localparam int N_W    = N_W_IN + N_HID * N_OUT,
  localparam int IDX_W  = $clog2(N_W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             keep_weights,
  input  logic [15:0]      seed,
  input  logic [7:0]       str_in,
  input  logic [7:0]       str_out,
  input  logic             ld_en,
  input  logic [PAT_W-1:0] ld_idx,
  input  logic [N_IN-1:0]  ld_pattern,
  input  logic [OUT_W-1:0] ld_target,
  input  logic [N_IN-1:0]  q_pattern,
  output logic             busy,
  output logic             done,
  output logic             success,
  output logic [ITW-1:0]   iteration_count,
  output logic [ERW-1:0]   pass_errors,
  output logic [OUT_W-1:0] q_class
);

  state_t              st;
  logic [N_IN-1:0]     pat_mem [N_PAT];
  logic [OUT_W-1:0]    tgt_mem [N_PAT];
  logic [PAT_W-1:0]    pat_idx;
  logic [IDX_W-1:0]    init_cnt;
  logic [ERW-1:0]      err_cnt;
  wgt_t                s_in_q, s_out_q;
  logic [HID_W-1:0]    hid_q;
  logic [OUT_W-1:0]    out_q;
  logic                miss_q;

  logic [RND_W-1:0]        rnd;
  logic [N_W*WGT_W-1:0]    wts;
  logic [N_IN-1:0]         x_eval;
  logic [N_HID*SUM_W-1:0]  hid_score;
  logic [N_OUT*WGT_W-1:0]  out_score;
  logic [HID_W-1:0]        hid_win;
  logic [OUT_W-1:0]        out_win;

  // Named internal events
  logic start_ok, eval_miss, upd_fire, dep_fire, pass_fire, pass_clean, pass_limit;

  assign start_ok   = start && (st == ST_IDLE);
  assign eval_miss  = (out_win != tgt_mem[pat_idx]);
  assign upd_fire   = (st == ST_UPD);
  assign dep_fire   = upd_fire && miss_q;
  assign pass_fire  = (st == ST_PASS);
  assign pass_clean = pass_fire && (err_cnt == '0);
  assign pass_limit = pass_fire && (err_cnt != '0) && (iteration_count == ITW'(MAX_PASSES - 1));
  assign busy       = (st != ST_IDLE);
  assign x_eval     = (st == ST_IDLE) ? q_pattern : pat_mem[pat_idx];
  assign q_class    = out_win;

  lfm_lfsr #(.W(RND_W)) u_lfsr (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (start_ok),
    .seed  (seed),
    .state (rnd)
  );

  lfm_weight_bank #(
    .N_IN(N_IN), .N_HID(N_HID), .N_OUT(N_OUT),
    .INIT_MEAN(INIT_MEAN), .SPREAD_BITS(SPREAD_BITS)
  ) u_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .init_en  (st == ST_INIT),
    .init_idx (init_cnt),
    .rnd      (rnd),
    .dep_en   (dep_fire),
    .dep_x    (pat_mem[pat_idx]),
    .dep_hid  (hid_q),
    .dep_out  (out_q),
    .str_in   (s_in_q),
    .str_out  (s_out_q),
    .wts_o    (wts)
  );

  // Hidden scores: sum of first-layer weights over active inputs.
  always_comb begin
    for (int j = 0; j < N_HID; j++) begin
      logic [SUM_W-1:0] acc;
      acc = '0;
      for (int i = 0; i < N_IN; i++)
        if (x_eval[i]) acc = acc + SUM_W'(wts[(i*N_HID + j)*WGT_W +: WGT_W]);
      hid_score[j*SUM_W +: SUM_W] = acc;
    end
  end

  lfm_wta #(.N(N_HID), .SW(SUM_W)) u_wta_hid (
    .score_i (hid_score),
    .win_o   (hid_win)
  );

  // Output scores: second-layer row of the single active hidden neuron.
  always_comb begin
    for (int k = 0; k < N_OUT; k++)
      out_score[k*WGT_W +: WGT_W] = wts[(N_W_IN + int'(hid_win)*N_OUT + k)*WGT_W +: WGT_W];
  end

  lfm_wta #(.N(N_OUT), .SW(WGT_W)) u_wta_out (
    .score_i (out_score),
    .win_o   (out_win)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int p = 0; p < N_PAT; p++) begin
        pat_mem[p] <= '0;
        tgt_mem[p] <= '0;
      end
    end else if (ld_en && (st == ST_IDLE) && (int'(ld_idx) < N_PAT)) begin
      pat_mem[ld_idx] <= ld_pattern;
      tgt_mem[ld_idx] <= ld_target;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st              <= ST_IDLE;
      done            <= 1'b0;
      success         <= 1'b0;
      iteration_count <= '0;
      pass_errors     <= '0;
      err_cnt         <= '0;
      pat_idx         <= '0;
      init_cnt        <= '0;
      s_in_q          <= '0;
      s_out_q         <= '0;
      hid_q           <= '0;
      out_q           <= '0;
      miss_q          <= 1'b0;
    end else begin
      unique case (st)
        ST_IDLE: if (start_ok) begin
          done            <= 1'b0;
          success         <= 1'b0;
          iteration_count <= '0;
          pass_errors     <= '0;
          err_cnt         <= '0;
          pat_idx         <= '0;
          init_cnt        <= '0;
          s_in_q          <= str_in;
          s_out_q         <= str_out;
          st              <= keep_weights ? ST_EVAL : ST_INIT;
        end
        ST_INIT: begin
          init_cnt <= init_cnt + 1'b1;
          if (init_cnt == IDX_W'(N_W - 1)) st <= ST_EVAL;
        end
        ST_EVAL: begin
          hid_q  <= hid_win;
          out_q  <= out_win;
          miss_q <= eval_miss;
          st     <= ST_UPD;
        end
        ST_UPD: begin
          err_cnt <= err_cnt + ERW'(miss_q);
          if (pat_idx == PAT_W'(N_PAT - 1)) begin
            st <= ST_PASS;
          end else begin
            pat_idx <= pat_idx + 1'b1;
            st      <= ST_EVAL;
          end
        end
        ST_PASS: begin
          iteration_count <= iteration_count + 1'b1;
          pass_errors     <= err_cnt;
          err_cnt         <= '0;
          pat_idx         <= '0;
          if (pass_clean) begin
            done    <= 1'b1;
            success <= 1'b1;
            st      <= ST_IDLE;
          end else if (pass_limit) begin
            done <= 1'b1;
            st   <= ST_IDLE;
          end else begin
            st <= ST_EVAL;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // Argmax witnesses for the assertions (independent of the WTA scan).
  logic hid_ok, out_ok;
  always_comb begin
    hid_ok = 1'b1;
    for (int j = 0; j < N_HID; j++) begin
      if (hid_score[j*SUM_W +: SUM_W] > hid_score[int'(hid_win)*SUM_W +: SUM_W]) hid_ok = 1'b0;
      if (j < int'(hid_win) &&
          hid_score[j*SUM_W +: SUM_W] == hid_score[int'(hid_win)*SUM_W +: SUM_W]) hid_ok = 1'b0;
    end
    out_ok = (int'(out_win) < N_OUT);
    for (int k = 0; k < N_OUT; k++) begin
      if (out_score[k*WGT_W +: WGT_W] > out_score[int'(out_win)*WGT_W +: WGT_W]) out_ok = 1'b0;
      if (k < int'(out_win) &&
          out_score[k*WGT_W +: WGT_W] == out_score[int'(out_win)*WGT_W +: WGT_W]) out_ok = 1'b0;
    end
  end

  a_r3_hidden_argmax: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_EVAL) |-> hid_ok);
  a_r3_output_argmax: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_EVAL) |-> out_ok);
  a_r4_match_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_fire && !miss_q) |=> $stable(wts));
  a_r7_errors_bound: assert property (@(posedge clk) disable iff (!rst_n)
    pass_errors <= ERW'(N_PAT));
  a_r8_clean_stops: assert property (@(posedge clk) disable iff (!rst_n)
    pass_clean |=> (done && success && !busy && pass_errors == '0));
  a_r8_success_done: assert property (@(posedge clk) disable iff (!rst_n)
    success |-> done);
  a_r9_pass_bound: assert property (@(posedge clk) disable iff (!rst_n)
    iteration_count <= ITW'(MAX_PASSES));
  a_r9_limit_fails: assert property (@(posedge clk) disable iff (!rst_n)
    pass_limit |=> (done && !success && iteration_count == ITW'(MAX_PASSES)));

endmodule

// File: tb/test_lfm_learner.sv
module test_lfm_learner;

  localparam int CLK_PERIOD = 10;
  localparam int N_IN  = 6;
  localparam int N_HID = 18;
  localparam int N_OUT = 6;
  localparam int N_PAT = 6;
  localparam int MAXP  = 300;
  localparam int N_W   = N_IN*N_HID + N_HID*N_OUT;
  localparam int LIMIT = N_W + MAXP*(2*N_PAT + 1) + 50;
  localparam int NVEC  = 1 << N_IN;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0, keep_weights = 1'b0, ld_en = 1'b0;
  logic [15:0] seed = '0;
  logic [7:0] str_in = '0, str_out = '0;
  logic [2:0] ld_idx = '0;
  logic [N_IN-1:0] ld_pattern = '0, q_pattern = '0;
  logic [2:0] ld_target = '0;
  logic       busy, done, success;
  logic [13:0] iteration_count_w;
  logic [8:0]  iteration_count;
  logic [2:0]  pass_errors, q_class;

  int n_tests = 0, n_fail = 0;
  int tgt [N_PAT];
  int snap_a [NVEC];
  int snap_b [NVEC];

  always #(CLK_PERIOD/2) clk = ~clk;

  lfm_learner #(.N_IN(N_IN), .N_HID(N_HID), .N_OUT(N_OUT), .N_PAT(N_PAT),
                .MAX_PASSES(MAXP)) i_lfm_learner (
    .clk(clk), .rst_n(rst_n), .start(start), .keep_weights(keep_weights),
    .seed(seed), .str_in(str_in), .str_out(str_out), .ld_en(ld_en),
    .ld_idx(ld_idx), .ld_pattern(ld_pattern), .ld_target(ld_target),
    .q_pattern(q_pattern), .busy(busy), .done(done), .success(success),
    .iteration_count(iteration_count), .pass_errors(pass_errors), .q_class(q_class)
  );
  assign iteration_count_w = 14'(iteration_count);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic load(input int idx, input int pat, input int t);
    @(negedge clk);
    ld_en = 1'b1; ld_idx = 3'(idx); ld_pattern = N_IN'(pat); ld_target = 3'(t);
    @(negedge clk);
    ld_en = 1'b0;
    tgt[idx] = t;
  endtask

  task automatic run(input bit keep, input int sd, input int si, input int so);
    int cyc;
    @(negedge clk);
    keep_weights = keep; seed = 16'(sd); str_in = 8'(si); str_out = 8'(so);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy && !done, "R2 busy/done after start", int'(busy), 1);
    cyc = 0;
    while (!done && cyc < LIMIT) begin
      @(negedge clk);
      cyc++;
    end
    if (!done) chk(1'b0, "R9 watchdog expired", cyc, LIMIT);
  endtask

  task automatic query(input int v, output int c);
    q_pattern = N_IN'(v);
    #1;
    c = int'(q_class);
  endtask

  task automatic sweep(output int s [NVEC]);
    for (int v = 0; v < NVEC; v++) begin
      int c;
      query(v, c);
      s[v] = c;
      chk(c < N_OUT, "R3 class in range", c, N_OUT - 1);
    end
    @(negedge clk);
  endtask

  initial begin
    int c, exp_err;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(!busy && !done && !success, "R1 idle flags", int'({busy, done, success}), 0);
    chk(iteration_count == 0 && pass_errors == 0, "R1 counters", int'(iteration_count), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2: one-hot patterns with distinct targets
    for (int p = 0; p < N_PAT; p++) load(p, 1 << p, (p*5 + 2) % N_OUT);

    // R11 / R8: convergence from several seeds
    for (int s = 0; s < 3; s++) begin
      run(1'b0, 16'h1234 + s*16'h3B1D, 90, 50);
      chk(done && success, "R8 success after clean pass", int'(success), 1);
      chk(pass_errors == 0, "R8 last pass clean", int'(pass_errors), 0);
      chk(iteration_count >= 1 && iteration_count <= MAXP, "R11 within pass limit",
          int'(iteration_count), MAXP);
      for (int p = 0; p < N_PAT; p++) begin
        query(1 << p, c);
        chk(c == tgt[p], "R11 R3 one-hot maps to target", c, tgt[p]);
      end
      @(negedge clk);
    end

    // R4 / R10: restart on learned weights, no changes
    sweep(snap_a);
    run(1'b1, 0, 90, 50);
    chk(success && iteration_count == 1, "R10 single clean pass", int'(iteration_count), 1);
    sweep(snap_b);
    for (int v = 0; v < NVEC; v++)
      chk(snap_b[v] == snap_a[v], "R4 mapping unchanged", snap_b[v], snap_a[v]);

    // R6 / R7 / R9: retarget last pattern, zero strengths -> timeout, no change
    load(N_PAT - 1, 1 << (N_PAT - 1), (tgt[N_PAT-1] + 1) % N_OUT);
    exp_err = 0;
    for (int p = 0; p < N_PAT; p++) if (snap_a[1 << p] != tgt[p]) exp_err++;
    run(1'b1, 0, 0, 0);
    chk(done && !success, "R9 run fails", int'(success), 0);
    chk(iteration_count == MAXP, "R9 pass limit", int'(iteration_count), MAXP);
    chk(pass_errors == exp_err, "R7 last-pattern miss counted", int'(pass_errors), exp_err);
    sweep(snap_b);
    for (int v = 0; v < NVEC; v++)
      chk(snap_b[v] == snap_a[v], "R6 zero strength leaves weights", snap_b[v], snap_a[v]);

    // R5: two patterns on input 4 with different targets, output layer frozen
    load(N_PAT - 1, 1 << 4, (tgt[4] + 3) % N_OUT);
    run(1'b1, 0, 120, 0);
    chk(done && !success && iteration_count == MAXP, "R9 conflict times out",
        int'(iteration_count), MAXP);
    chk(pass_errors >= 1, "R7 conflict errors nonzero", int'(pass_errors), 1);
    sweep(snap_b);
    for (int v = 0; v < NVEC; v++)
      if (((v >> 4) & 1) == 0)
        chk(snap_b[v] == snap_a[v], "R5 rows off the path unchanged", snap_b[v], snap_a[v]);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule